// File: doc/BRIEF.md
# Keyboard Controller Host Register Interface

This block is the host-facing side of a keyboard-style peripheral controller. A host reaches it over a byte-wide bus with an address, a read strobe, a write strobe and write/read data lines. Two addresses are decoded. The control address reads back an eight-flag status byte and accepts command bytes on writes. The data address returns the output register on reads and loads the input register on writes. A parameter selects the address map. In port mode the control address is 0x64 and the data address is 0x60. In memory-mapped mode the status byte is at offset 0, the data byte is at offset 4, and the three bytes between them are padding.

On the device side, a one-cycle scan-code strobe places a byte in the output register for the host to collect. A byte that the host writes to the input register is handed to the device side a fixed number of cycles later on a one-cycle strobe. The command 0xAE runs a fixed-length self-test, and the pass byte 0x55 then appears in the output register. Two further commands set and clear an interrupt enable. While the enable is set, the interrupt line follows the output-full flag.

There are three small state machines. The output buffer (`OB_EMPTY`, `OB_FULL`) moves to `OB_FULL` on an accepted scan code or a self-test result, and moves to `OB_EMPTY` on a host data read. The input buffer (`IB_IDLE`, `IB_HOLD`) moves to `IB_HOLD` on a host data write, and returns to `IB_IDLE` when its hold counter runs out, which is also when the strobe to the device fires. The command unit (`CT_IDLE`, `CT_TEST`, `CT_REPORT`) moves to `CT_TEST` on 0xAE, to `CT_REPORT` when the test counter runs out, and back to `CT_IDLE` after one cycle, during which it loads the result.

Top module: `keyctl_regs`

## Requirements
- R1: After reset the status byte reads 0x00, the interrupt line is low and the input-to-device strobe is low.
- R2: A scan code that arrives while status bit 0 is 0 is stored in the output register. From the next cycle on, status bit 0 reads 1 and a read of the data address returns that code.
- R3: A host read of the data address returns the output register during the read cycle, and status bit 0 reads 0 from the following cycle on.
- R4: A scan code that arrives while status bit 0 is 1 is dropped. The output register keeps its byte and status bit 7 (overrun) is set.
- R5: Status bit 7 is sticky. A status read still returns it as 1, and it reads 0 from the cycle after that read.
- R6: A host write to the data address while status bit 1 is 0 sets bit 1 for exactly CONSUME_CYCLES cycles. In the cycle bit 1 clears, the device strobe is high for one cycle with the written byte on the device data output. A data write while bit 1 is 1 is ignored.
- R7: Command 0xAE written to the control address sets status bit 2 (busy) for exactly TEST_CYCLES cycles. One cycle after busy clears, the output register holds 0x55, replacing any byte it held, and bit 0 reads 1. A further 0xAE while busy is ignored and does not lengthen the test.
- R8: Command 0xC1 sets the interrupt enable, which reads back as status bit 3, and command 0xC0 clears it. Every other command byte except 0xAE changes no status bit.
- R9: The interrupt line is high exactly when status bit 0 and the interrupt enable are both 1.
- R10: In port mode the control address is 0x64 and the data address is 0x60. In memory-mapped mode they are 0 and 4. A read of any other address returns 0x00, and a write to any other address has no effect.
- R11: Status bits 4, 5 and 6 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Host address |
| bus_rd | input | 1 | Host read strobe, one cycle per access |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, valid while bus_rd is high |
| scan_valid | input | 1 | Device-side scan-code strobe |
| scan_code | input | 8 | Device-side scan code |
| in_byte | output | 8 | Input register contents presented to the device |
| in_strobe | output | 1 | One-cycle pulse when the device consumes the input register |
| irq | output | 1 | Interrupt request: output data present and enabled |

## Verification
All 256 scan codes are pushed through the empty output buffer, and each round trip checks the status byte, the data byte and the cleared flag, so any corrupted or stuck data bit shows up. All 256 host data bytes go through the input buffer, which checks the bit-1 window length and the device strobe timing cycle by cycle. All 256 command bytes are written, which separates the three commands that act from the 253 that must leave the status byte alone. Targeted sequences cover the cases where the two buffers and the commands interact: back-to-back scan codes for overrun, a repeated self-test command, a self-test result over a held byte, the interrupt enable with the buffer full and empty, and addresses outside the map in both modes.

// File: rtl/keyctl_pkg.sv
package keyctl_pkg;

    // Status flag positions; the host polls these bits.
    localparam int ST_OUT_FULL = 0;
    localparam int ST_IN_FULL  = 1;
    localparam int ST_BUSY     = 2;
    localparam int ST_IEN      = 3;
    localparam int ST_OVERRUN  = 7;

    // Command codes accepted on the control address.
    localparam logic [7:0] CMD_SELFTEST = 8'hAE;
    localparam logic [7:0] CMD_IRQ_ON   = 8'hC1;
    localparam logic [7:0] CMD_IRQ_OFF  = 8'hC0;

    // Byte reported on a passing self-test.
    localparam logic [7:0] TEST_PASS    = 8'h55;

    typedef enum logic {OB_EMPTY, OB_FULL} ob_state_t;
    typedef enum logic {IB_IDLE, IB_HOLD} ib_state_t;
    typedef enum logic [1:0] {CT_IDLE, CT_TEST, CT_REPORT} ct_state_t;

endpackage

// File: rtl/keyctl_decode.sv
module keyctl_decode #(
    parameter int ADDR_W  = 8,
    parameter bit MM_MODE = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output logic              stat_rd,
    output logic              data_rd,
    output logic              cmd_wr,
    output logic              data_wr
);

    logic hit_ctl;
    logic hit_dat;

    generate
        if (MM_MODE) begin : g_mmio
            // Status byte at offset 0, data byte at offset 4.
            assign hit_ctl = (addr == ADDR_W'(0));
            assign hit_dat = (addr == ADDR_W'(4));
        end else begin : g_port
            assign hit_ctl = (addr == ADDR_W'(8'h64));
            assign hit_dat = (addr == ADDR_W'(8'h60));
        end
    endgenerate

    assign stat_rd = rd & hit_ctl;
    assign data_rd = rd & hit_dat;
    assign cmd_wr  = wr & hit_ctl;
    assign data_wr = wr & hit_dat;

endmodule

// File: rtl/keyctl_outbuf.sv
module keyctl_outbuf
    import keyctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scan_valid,
    input  logic [7:0] scan_code,
    input  logic       res_load,
    input  logic       data_rd,
    input  logic       stat_rd,
    output logic       out_full,
    output logic [7:0] out_data,
    output logic       overrun
);

    ob_state_t  ob_q, ob_d;
    logic [7:0] data_q, data_d;
    logic       ovr_q, ovr_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ob_q   <= OB_EMPTY;
            data_q <= 8'h00;
            ovr_q  <= 1'b0;
        end else begin
            ob_q   <= ob_d;
            data_q <= data_d;
            ovr_q  <= ovr_d;
        end
    end

    always_comb begin
        ob_d   = ob_q;
        data_d = data_q;
        ovr_d  = ovr_q;
        if (stat_rd) begin
            ovr_d = 1'b0;
        end
        unique case (ob_q)
            OB_EMPTY: begin
                if (res_load) begin
                    // Self-test result wins; a scan in the same cycle is lost.
                    data_d = TEST_PASS;
                    ob_d   = OB_FULL;
                    if (scan_valid) ovr_d = 1'b1;
                end else if (scan_valid) begin
                    data_d = scan_code;
                    ob_d   = OB_FULL;
                end
            end
            OB_FULL: begin
                if (data_rd) ob_d = OB_EMPTY;
                if (res_load) begin
                    data_d = TEST_PASS;
                    ob_d   = OB_FULL;
                end
                if (scan_valid) ovr_d = 1'b1;
            end
            default: ob_d = OB_EMPTY;
        endcase
    end

    assign out_full = (ob_q == OB_FULL);
    assign out_data = data_q;
    assign overrun  = ovr_q;

endmodule

// File: rtl/keyctl_inbuf.sv
module keyctl_inbuf
    import keyctl_pkg::*;
#(
    parameter int CONSUME_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       data_wr,
    input  logic [7:0] wr_data,
    output logic       in_full,
    output logic [7:0] in_byte,
    output logic       in_strobe
);

    localparam int CW = (CONSUME_CYCLES > 1) ? $clog2(CONSUME_CYCLES) : 1;

    ib_state_t   ib_q, ib_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [7:0]  byte_q, byte_d;
    logic        stb_q, stb_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ib_q   <= IB_IDLE;
            cnt_q  <= '0;
            byte_q <= 8'h00;
            stb_q  <= 1'b0;
        end else begin
            ib_q   <= ib_d;
            cnt_q  <= cnt_d;
            byte_q <= byte_d;
            stb_q  <= stb_d;
        end
    end

    always_comb begin
        ib_d   = ib_q;
        cnt_d  = cnt_q;
        byte_d = byte_q;
        stb_d  = 1'b0;
        unique case (ib_q)
            IB_IDLE: begin
                if (data_wr) begin
                    byte_d = wr_data;
                    cnt_d  = CW'(CONSUME_CYCLES - 1);
                    ib_d   = IB_HOLD;
                end
            end
            IB_HOLD: begin
                // Writes during the hold window are ignored.
                if (cnt_q == '0) begin
                    stb_d = 1'b1;
                    ib_d  = IB_IDLE;
                end else begin
                    cnt_d = cnt_q - CW'(1);
                end
            end
            default: ib_d = IB_IDLE;
        endcase
    end

    assign in_full   = (ib_q == IB_HOLD);
    assign in_byte   = byte_q;
    assign in_strobe = stb_q;

endmodule

// File: rtl/keyctl_cmd.sv
module keyctl_cmd
    import keyctl_pkg::*;
#(
    parameter int TEST_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic [7:0] cmd_byte,
    output logic       busy,
    output logic       res_load,
    output logic       ien
);

    localparam int TW = (TEST_CYCLES > 1) ? $clog2(TEST_CYCLES) : 1;

    ct_state_t     ct_q, ct_d;
    logic [TW-1:0] cnt_q, cnt_d;
    logic          ien_q, ien_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ct_q  <= CT_IDLE;
            cnt_q <= '0;
            ien_q <= 1'b0;
        end else begin
            ct_q  <= ct_d;
            cnt_q <= cnt_d;
            ien_q <= ien_d;
        end
    end

    always_comb begin
        ct_d  = ct_q;
        cnt_d = cnt_q;
        ien_d = ien_q;
        if (cmd_wr && cmd_byte == CMD_IRQ_ON)  ien_d = 1'b1;
        if (cmd_wr && cmd_byte == CMD_IRQ_OFF) ien_d = 1'b0;
        unique case (ct_q)
            CT_IDLE: begin
                if (cmd_wr && cmd_byte == CMD_SELFTEST) begin
                    cnt_d = TW'(TEST_CYCLES - 1);
                    ct_d  = CT_TEST;
                end
            end
            CT_TEST: begin
                if (cnt_q == '0) ct_d = CT_REPORT;
                else             cnt_d = cnt_q - TW'(1);
            end
            CT_REPORT: ct_d = CT_IDLE;
            default:   ct_d = CT_IDLE;
        endcase
    end

    assign busy     = (ct_q == CT_TEST);
    assign res_load = (ct_q == CT_REPORT);
    assign ien      = ien_q;

endmodule

// File: rtl/keyctl_regs.sv
module keyctl_regs
    import keyctl_pkg::*;
#(
    parameter int ADDR_W         = 8,
    parameter bit MM_MODE        = 1'b0,
    parameter int CONSUME_CYCLES = 4,
    parameter int TEST_CYCLES    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              scan_valid,
    input  logic [7:0]        scan_code,
    output logic [7:0]        in_byte,
    output logic              in_strobe,
    output logic              irq
);

    logic       stat_rd, data_rd, cmd_wr, data_wr;
    logic       out_full, overrun, in_full, busy, res_load, ien;
    logic [7:0] out_data;
    logic [7:0] st_byte;

    keyctl_decode #(.ADDR_W(ADDR_W), .MM_MODE(MM_MODE)) u_dec (
        .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
        .stat_rd(stat_rd), .data_rd(data_rd), .cmd_wr(cmd_wr), .data_wr(data_wr)
    );

    keyctl_outbuf u_out (
        .clk(clk), .rst_n(rst_n), .scan_valid(scan_valid), .scan_code(scan_code),
        .res_load(res_load), .data_rd(data_rd), .stat_rd(stat_rd),
        .out_full(out_full), .out_data(out_data), .overrun(overrun)
    );

    keyctl_inbuf #(.CONSUME_CYCLES(CONSUME_CYCLES)) u_in (
        .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .wr_data(bus_wdata),
        .in_full(in_full), .in_byte(in_byte), .in_strobe(in_strobe)
    );

    keyctl_cmd #(.TEST_CYCLES(TEST_CYCLES)) u_cmd (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_byte(bus_wdata),
        .busy(busy), .res_load(res_load), .ien(ien)
    );

    always_comb begin
        st_byte              = 8'h00;
        st_byte[ST_OUT_FULL] = out_full;
        st_byte[ST_IN_FULL]  = in_full;
        st_byte[ST_BUSY]     = busy;
        st_byte[ST_IEN]      = ien;
        st_byte[ST_OVERRUN]  = overrun;
    end

    always_comb begin
        if (stat_rd)      bus_rdata = st_byte;
        else if (data_rd) bus_rdata = out_data;
        else              bus_rdata = 8'h00;
    end

    assign irq = out_full & ien;

endmodule

// File: rtl/keyctl_checker.sv
module keyctl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] status,
    input logic [7:0] out_data,
    input logic       stat_rd,
    input logic       data_rd,
    input logic       scan_valid,
    input logic       res_load,
    input logic       in_strobe,
    input logic       irq
);

    p_overrun_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(status[7]) && !$past(stat_rd)) |-> status[7]);

    p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && status[0] && !scan_valid && !res_load) |=> !status[0]);

    p_drop_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && scan_valid && !data_rd && !res_load) |=> (status[7] && $stable(out_data)));

    p_strobe_at_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[1]) |-> in_strobe);

    p_strobe_needs_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_strobe |-> (!status[1] && $past(status[1])));

    p_result_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[2]) |=> (status[0] && out_data == 8'h55));

    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status[0] && status[3]));

    p_reserved_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        status[6:4] == 3'b000);

endmodule

bind keyctl_regs keyctl_checker u_chk (
    .clk(clk), .rst_n(rst_n), .status(st_byte), .out_data(out_data),
    .stat_rd(stat_rd), .data_rd(data_rd), .scan_valid(scan_valid),
    .res_load(res_load), .in_strobe(in_strobe), .irq(irq)
);

// File: tb/tb_keyctl_regs.sv
`timescale 1ns/1ps
module tb_keyctl_regs;

    localparam int CC = 4;
    localparam int TC = 16;
    localparam logic [7:0] STAT = 8'h64;
    localparam logic [7:0] DATA = 8'h60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0;
    logic [7:0] addr = 8'h00, wdata = 8'h00, scode = 8'h00;
    logic rd = 1'b0, wr = 1'b0, sv = 1'b0;
    logic [7:0] rdata_p, rdata_m, inb_p, inb_m;
    logic stb_p, stb_m, irq_p, irq_m;
    int errors = 0, checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    keyctl_regs #(.ADDR_W(8), .MM_MODE(1'b0), .CONSUME_CYCLES(CC), .TEST_CYCLES(TC)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_rd(rd & ~sel), .bus_wr(wr & ~sel),
        .bus_wdata(wdata), .bus_rdata(rdata_p), .scan_valid(sv & ~sel), .scan_code(scode),
        .in_byte(inb_p), .in_strobe(stb_p), .irq(irq_p));

    keyctl_regs #(.ADDR_W(8), .MM_MODE(1'b1), .CONSUME_CYCLES(CC), .TEST_CYCLES(TC)) dut_mm (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_rd(rd & sel), .bus_wr(wr & sel),
        .bus_wdata(wdata), .bus_rdata(rdata_m), .scan_valid(sv & sel), .scan_code(scode),
        .in_byte(inb_m), .in_strobe(stb_m), .irq(irq_m));

    wire [7:0] rdata = sel ? rdata_m : rdata_p;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input logic [7:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic host_rd(input logic [7:0] a, output logic [7:0] d);
        addr = a; rd = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic scan(input logic [7:0] c);
        scode = c; sv = 1'b1;
        @(negedge clk);
        sv = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", {7'd0, irq_p}, 8'h00);
        check("R1 strobe", {7'd0, stb_p}, 8'h00);
        host_rd(STAT, v); check("R1 status", v, 8'h00);

        // R2 R3 sweep every scan code through the empty buffer
        for (int c = 0; c < 256; c++) begin
            scan(8'(c));
            host_rd(STAT, v); check("R2 status full", v, 8'h01);
            host_rd(DATA, v); check("R2 data", v, 8'(c));
            host_rd(STAT, v); check("R3 status cleared", v, 8'h00);
        end

        // R4 R5 overrun
        scan(8'hA1); scan(8'hB2);
        host_rd(STAT, v); check("R4 R5 overrun seen", v, 8'h81);
        host_rd(STAT, v); check("R5 overrun cleared", v, 8'h01);
        host_rd(DATA, v); check("R4 first kept", v, 8'hA1);
        host_rd(STAT, v); check("R4 empty", v, 8'h00);

        // R6 sweep every host data byte
        for (int d = 0; d < 256; d++) begin
            host_wr(DATA, 8'(d));
            addr = STAT; rd = 1'b1;
            for (int k = 0; k <= CC; k++) begin
                #1;
                check("R6 in-full window", {7'd0, rdata[1]}, (k < CC) ? 8'h01 : 8'h00);
                check("R6 strobe", {7'd0, stb_p}, (k == CC) ? 8'h01 : 8'h00);
                if (k == CC) check("R6 byte", inb_p, 8'(d));
                @(negedge clk);
            end
            rd = 1'b0;
        end
        // R6 write while full is ignored
        host_wr(DATA, 8'h3A);
        host_wr(DATA, 8'hC5);
        repeat (CC) @(negedge clk);
        host_rd(STAT, v); check("R6 idle after ignore", v, 8'h00);
        check("R6 ignored write", inb_p, 8'h3A);

        // R7 self-test timing from empty buffer
        host_wr(STAT, 8'hAE);
        addr = STAT; rd = 1'b1;
        for (int k = 0; k <= TC + 1; k++) begin
            #1;
            check("R7 busy", {7'd0, rdata[2]}, (k < TC) ? 8'h01 : 8'h00);
            check("R7 full", {7'd0, rdata[0]}, (k == TC + 1) ? 8'h01 : 8'h00);
            @(negedge clk);
        end
        rd = 1'b0;
        host_rd(DATA, v); check("R7 pass byte", v, 8'h55);

        // R7 repeated command does not extend; result replaces held byte
        scan(8'h3C);
        host_wr(STAT, 8'hAE);
        host_wr(STAT, 8'hAE);
        addr = STAT; rd = 1'b1;
        for (int k = 1; k <= TC; k++) begin
            #1;
            check("R7 no extend", {7'd0, rdata[2]}, (k < TC) ? 8'h01 : 8'h00);
            @(negedge clk);
        end
        rd = 1'b0;
        host_rd(DATA, v); check("R7 replaces held", v, 8'h55);
        host_rd(STAT, v); check("R7 after read", v, 8'h00);

        // R8 every other command byte leaves status alone
        for (int c = 0; c < 256; c++) begin
            if (c != 8'hAE && c != 8'hC0 && c != 8'hC1) begin
                host_wr(STAT, 8'(c));
                host_rd(STAT, v); check("R8 no effect", v, 8'h00);
            end
        end

        // R8 R9 interrupt enable
        host_wr(STAT, 8'hC1);
        host_rd(STAT, v); check("R8 enable", v, 8'h08);
        check("R9 no data no irq", {7'd0, irq_p}, 8'h00);
        scan(8'h77);
        #1 check("R9 irq on", {7'd0, irq_p}, 8'h01);
        host_wr(STAT, 8'hC0);
        #1 check("R9 irq off when disabled", {7'd0, irq_p}, 8'h00);
        host_rd(STAT, v); check("R8 disable", v, 8'h01);
        host_wr(STAT, 8'hC1);
        host_rd(DATA, v); check("R9 data", v, 8'h77);
        #1 check("R9 irq drops on read", {7'd0, irq_p}, 8'h00);
        host_wr(STAT, 8'hC0);

        // R10 port map: other addresses
        scan(8'h42);
        host_rd(8'h61, v); check("R10 unmapped read", v, 8'h00);
        host_rd(8'h00, v); check("R10 offset0 not status in port mode", v, 8'h00);
        host_wr(8'h62, 8'hAE);
        host_wr(8'h04, 8'h11);
        host_rd(STAT, v); check("R10 unmapped writes", v, 8'h01);
        host_rd(DATA, v); check("R10 data", v, 8'h42);

        // R10 memory-mapped instance
        sel = 1'b1;
        host_rd(8'h00, v); check("R10 mm status reset", v, 8'h00);
        scan(8'h9E);
        host_rd(8'h00, v); check("R10 mm status", v, 8'h01);
        host_rd(8'h64, v); check("R10 mm port addr unmapped", v, 8'h00);
        host_rd(8'h02, v); check("R10 mm pad", v, 8'h00);
        host_rd(8'h04, v); check("R10 mm data", v, 8'h9E);
        host_wr(8'h04, 8'h5B);
        host_rd(8'h00, v); check("R10 mm input full", v, 8'h02);
        sel = 1'b0;

        // R11 reserved bits after mixed activity
        scan(8'h01); scan(8'h02);
        host_wr(STAT, 8'hC1);
        host_rd(STAT, v); check("R11 reserved zero", v & 8'h70, 8'h00);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule